// File: doc/BRIEF.md
# Level-Crossing Sample Text Line Formatter

This block takes one level-crossing event, made of a crossing-direction flag and an unsigned elapsed-time count, and turns it into a fixed-length line of printable text. The result is handed one byte at a time to a byte-wide serial transmitter. The direction flag acts as the sign of the value, so a record can show any value from minus to plus the largest count. The count is converted to decimal digits by a shift-and-correct routine that advances one bit per clock. This routine always ends before the first character leaves the block.

Every record has the same layout: a sign character, the zero-padded decimal digits with the most significant digit first, then a carriage return and a line feed. With the default 16-bit count, a record is eight characters long. At ten serial bit times per character, that is eighty bit times per event. Both sides of the block use a valid/ready handshake. The block takes no new event until the line feed of the current record has been accepted downstream.

Top module: `lc_sample_fmt`

## Requirements
- R1: After reset, `smp_ready` is 1 and `byte_valid` is 0.
- R2: The first byte of a record is 8'h2B ('+') when `smp_upper` was 1 at acceptance and 8'h2D ('-') when it was 0. This holds for a zero count too.
- R3: Bytes 2 to 6 are the ASCII digits 8'h30 to 8'h39 of the accepted count in decimal, zero-padded to DIGITS places (5 by default) and sent most significant digit first.
- R4: Byte 7 is 8'h0D (carriage return) and byte 8 is 8'h0A (line feed).
- R5: A record is exactly DIGITS+3 bytes. `byte_valid` stays 1 from the first byte until the line feed is accepted, and is 0 in the cycle after that.
- R6: `smp_ready` is 0 from the accepting edge until the line feed is accepted. An event offered in that window is ignored and produces no output.
- R7: While `byte_valid` is 1 and `byte_ready` is 0, `byte_valid` and `byte_data` hold their values.
- R8: The extreme counts format correctly: count 0 gives all-zero digits and count 65535 gives "65535", with either sign.
- R9: `byte_valid` rises exactly TIME_W clock edges after the edge that accepts an event.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Event offered |
| smp_ready | output | 1 | Block is idle and takes an event |
| smp_upper | input | 1 | 1 = upper threshold crossed, 0 = lower |
| smp_count | input | TIME_W | Elapsed-time count of the event |
| byte_valid | output | 1 | Output character offered |
| byte_ready | input | 1 | Downstream takes the character |
| byte_data | output | 8 | ASCII character |

## Verification
The bench runs counts whose digits need a correction in every decimal place, along with the all-zero and all-nines-like extremes of both signs. A converter that corrects at the wrong point, or drops a carry, would print wrong digits. It applies stall patterns on the output side, which expose a sequencer that skips, repeats or changes a character while stalled. It offers a new event while a record is still being sent, which catches a design that overwrites the held value or emits a spurious second record. It also counts the cycles from acceptance to the first character, which catches an off-by-one in the conversion step counter.

// File: rtl/lcf_pkg.sv
package lcf_pkg;
   localparam logic [7:0] CH_PLUS  = 8'h2B;
   localparam logic [7:0] CH_MINUS = 8'h2D;
   localparam logic [7:0] CH_ZERO  = 8'h30;
   localparam logic [7:0] CH_CR    = 8'h0D;
   localparam logic [7:0] CH_LF    = 8'h0A;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_EMIT = 2'd2
   } fmt_state_e;

   // 10**n as a 64-bit value, used for elaboration-time range checks
   function automatic longint unsigned pow10(input int n);
      longint unsigned r;
      r = 1;
      for (int i = 0; i < n; i++) r = r * 10;
      return r;
   endfunction
endpackage

// File: rtl/lcf_digit_adj.sv
// One BCD place of the shift-and-correct converter: add 3 when the place is 5 or more
module lcf_digit_adj (
   input  logic [3:0] nib_in,
   output logic [3:0] nib_out
);
   always_comb begin
      if (nib_in >= 4'd5) nib_out = nib_in + 4'd3;
      else                nib_out = nib_in;
   end
endmodule

// File: rtl/lcf_dabble.sv
// Sequential binary to BCD converter, one input bit per clock
module lcf_dabble #(
   parameter int TIME_W = 16,
   parameter int DIGITS = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [TIME_W-1:0]     din,
   output logic                  busy,
   output logic                  done,
   output logic [4*DIGITS-1:0]   bcd
);
   localparam int SW   = 4 * DIGITS;
   localparam int CW   = $clog2(TIME_W + 1);
   localparam int LAST = TIME_W - 1;

   logic [TIME_W-1:0] bin_q;
   logic [SW-1:0]     bcd_q;
   logic [SW-1:0]     adj;
   logic [CW-1:0]     cnt_q;
   logic              busy_q;

   for (genvar g = 0; g < DIGITS; g++) begin : g_place
      lcf_digit_adj u_adj (
         .nib_in  (bcd_q[4*g +: 4]),
         .nib_out (adj[4*g +: 4])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         bin_q  <= '0;
         bcd_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b0;
      end else if (start) begin
         bin_q  <= din;
         bcd_q  <= '0;
         cnt_q  <= '0;
         busy_q <= 1'b1;
      end else if (busy_q) begin
         bcd_q  <= {adj[SW-2:0], bin_q[TIME_W-1]};
         bin_q  <= {bin_q[TIME_W-2:0], 1'b0};
         cnt_q  <= cnt_q + 1'b1;
         if (cnt_q == CW'(LAST)) busy_q <= 1'b0;
      end
   end

   assign busy = busy_q;
   assign done = busy_q && (cnt_q == CW'(LAST));
   assign bcd  = bcd_q;
endmodule

// File: rtl/lcf_char_sel.sv
// Picks the character for a record position
module lcf_char_sel
   import lcf_pkg::*;
#(
   parameter int DIGITS = 5,
   parameter int IDX_W  = 3
) (
   input  logic [IDX_W-1:0]    idx,
   input  logic                upper,
   input  logic [4*DIGITS-1:0] bcd,
   output logic [7:0]          ch
);
   localparam int POS_CR = DIGITS + 1;
   localparam int POS_LF = DIGITS + 2;

   logic [7:0] dch [DIGITS];

   // dch[0] is the most significant place
   for (genvar g = 0; g < DIGITS; g++) begin : g_dig
      assign dch[g] = CH_ZERO | {4'h0, bcd[4*(DIGITS-1-g) +: 4]};
   end

   always_comb begin
      ch = CH_LF;
      if (idx == '0) begin
         ch = upper ? CH_PLUS : CH_MINUS;
      end else if (idx == IDX_W'(POS_CR)) begin
         ch = CH_CR;
      end else if (idx == IDX_W'(POS_LF)) begin
         ch = CH_LF;
      end else begin
         for (int i = 0; i < DIGITS; i++) begin
            if (idx == IDX_W'(i + 1)) ch = dch[i];
         end
      end
   end
endmodule

// File: rtl/lcf_seq.sv
// Record sequencer: event handshake, conversion wait, byte emission
module lcf_seq
   import lcf_pkg::*;
#(
   parameter int DIGITS = 5,
   parameter int IDX_W  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             smp_valid,
   output logic             smp_ready,
   input  logic             smp_upper,
   output logic             conv_start,
   input  logic             conv_done,
   output logic             byte_valid,
   input  logic             byte_ready,
   output logic [IDX_W-1:0] idx,
   output logic             upper
);
   localparam int POS_LF = DIGITS + 2;

   fmt_state_e       st_q;
   logic [IDX_W-1:0] idx_q;
   logic             upper_q;

   assign smp_ready  = (st_q == ST_IDLE);
   assign conv_start = smp_ready && smp_valid;
   assign byte_valid = (st_q == ST_EMIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         idx_q   <= '0;
         upper_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: if (smp_valid) begin
               st_q    <= ST_CONV;
               upper_q <= smp_upper;
            end
            ST_CONV: if (conv_done) begin
               st_q  <= ST_EMIT;
               idx_q <= '0;
            end
            ST_EMIT: if (byte_ready) begin
               if (idx_q == IDX_W'(POS_LF)) begin
                  st_q  <= ST_IDLE;
                  idx_q <= '0;
               end else begin
                  idx_q <= idx_q + 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign idx   = idx_q;
   assign upper = upper_q;
endmodule

// File: rtl/lc_sample_fmt.sv
module lc_sample_fmt
   import lcf_pkg::*;
#(
   parameter int TIME_W = 16,
   parameter int DIGITS = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic              smp_upper,
   input  logic [TIME_W-1:0] smp_count,
   output logic              byte_valid,
   input  logic              byte_ready,
   output logic [7:0]        byte_data
);
   localparam int REC_LEN = DIGITS + 3;
   localparam int IDX_W   = $clog2(REC_LEN);

   if (TIME_W < 2 || TIME_W > 60) begin : g_bad_w
      $error("lc_sample_fmt: TIME_W out of range");
   end
   if (DIGITS < 1) begin : g_bad_d
      $error("lc_sample_fmt: DIGITS must be positive");
   end
   if (TIME_W <= 60 && pow10(DIGITS) < (64'd1 << TIME_W)) begin : g_short
      $error("lc_sample_fmt: DIGITS too few for TIME_W");
   end

   logic              conv_start;
   logic              conv_done;
   logic              conv_busy;
   logic [4*DIGITS-1:0] bcd;
   logic [IDX_W-1:0]  idx;
   logic              upper;

   lcf_seq #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .smp_valid  (smp_valid),
      .smp_ready  (smp_ready),
      .smp_upper  (smp_upper),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .byte_valid (byte_valid),
      .byte_ready (byte_ready),
      .idx        (idx),
      .upper      (upper)
   );

   lcf_dabble #(.TIME_W(TIME_W), .DIGITS(DIGITS)) u_conv (
      .clk   (clk),
      .rst_n (rst_n),
      .start (conv_start),
      .din   (smp_count),
      .busy  (conv_busy),
      .done  (conv_done),
      .bcd   (bcd)
   );

   lcf_char_sel #(.DIGITS(DIGITS), .IDX_W(IDX_W)) u_sel (
      .idx   (idx),
      .upper (upper),
      .bcd   (bcd),
      .ch    (byte_data)
   );
endmodule

// File: rtl/lcf_fmt_checker.sv
module lcf_fmt_checker #(
   parameter int TIME_W = 16,
   parameter int DIGITS = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             smp_valid,
   input logic             smp_ready,
   input logic             byte_valid,
   input logic             byte_ready,
   input logic [7:0]       byte_data
);
   localparam int LAST = DIGITS + 2;
   localparam int PW   = $clog2(LAST + 1);
   localparam int LW   = $clog2(TIME_W + 2) + 1;

   logic [PW-1:0] pos_q;
   logic [LW-1:0] lat_q;
   logic          past_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q      <= '0;
         lat_q      <= '0;
         past_valid <= 1'b0;
      end else begin
         past_valid <= 1'b1;
         if (byte_valid && byte_ready)
            pos_q <= (pos_q == PW'(LAST)) ? '0 : pos_q + 1'b1;
         if (smp_valid && smp_ready) lat_q <= '0;
         else if (!byte_valid && lat_q != '1) lat_q <= lat_q + 1'b1;
      end
   end

   // R1
   a_r1_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !past_valid |-> (smp_ready && !byte_valid));
   // R2
   a_r2_sign_char: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && pos_q == '0) |-> (byte_data == 8'h2B || byte_data == 8'h2D));
   // R3
   a_r3_digit_char: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && pos_q != '0 && pos_q <= PW'(DIGITS))
      |-> (byte_data >= 8'h30 && byte_data <= 8'h39));
   // R4
   a_r4_cr_char: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && pos_q == PW'(DIGITS + 1)) |-> byte_data == 8'h0D);
   a_r4_lf_char: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && pos_q == PW'(LAST)) |-> byte_data == 8'h0A);
   // R5
   a_r5_record_end: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && byte_ready && pos_q == PW'(LAST)) |=> (!byte_valid && smp_ready));
   // R6
   a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      !(smp_ready && byte_valid));
   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));
   // R9
   a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (past_valid && $rose(byte_valid)) |-> lat_q == LW'(TIME_W));
endmodule

bind lc_sample_fmt lcf_fmt_checker #(.TIME_W(TIME_W), .DIGITS(DIGITS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_valid  (smp_valid),
   .smp_ready  (smp_ready),
   .byte_valid (byte_valid),
   .byte_ready (byte_ready),
   .byte_data  (byte_data)
);

// File: tb/lc_sample_fmt_tb_top.sv
module lc_sample_fmt_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int TW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          smp_valid = 1'b0;
   logic          smp_ready;
   logic          smp_upper = 1'b0;
   logic [TW-1:0] smp_count = '0;
   logic          byte_valid;
   logic          byte_ready = 1'b0;
   logic [7:0]    byte_data;

   int checks = 0;
   int failures = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   lc_sample_fmt #(.TIME_W(TW), .DIGITS(5)) dut_i (
      .clk (clk), .rst_n (rst_n),
      .smp_valid (smp_valid), .smp_ready (smp_ready),
      .smp_upper (smp_upper), .smp_count (smp_count),
      .byte_valid (byte_valid), .byte_ready (byte_ready),
      .byte_data (byte_data)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic expect_line(input bit up, input int v, output logic [7:0] e [8]);
      int r;
      r = v;
      e[0] = up ? 8'h2B : 8'h2D;
      for (int i = 5; i >= 1; i--) begin
         e[i] = 8'h30 + 8'(r % 10);
         r = r / 10;
      end
      e[6] = 8'h0D;
      e[7] = 8'h0A;
   endtask

   // Offers an event from idle; optionally keeps offering another one while busy.
   task automatic send(input bit up, input int v, input bit hold_other);
      int lat;
      @(negedge clk);
      check(smp_ready == 1'b1, "R6 idle before event", int'(smp_ready), 1);
      smp_valid = 1'b1;
      smp_upper = up;
      smp_count = TW'(v);
      @(negedge clk);
      lat = 1;
      if (hold_other) begin
         smp_upper = ~up;
         smp_count = TW'(v ^ 16'h5A5A);
      end else smp_valid = 1'b0;
      check(smp_ready == 1'b0, "R6 busy after accept", int'(smp_ready), 0);
      while (!byte_valid && lat < 100) begin
         @(negedge clk);
         lat++;
         if (hold_other)
            check(smp_ready == 1'b0, "R6 ready low while busy", int'(smp_ready), 0);
      end
      smp_valid = 1'b0;
      // first valid seen at the negedge after TW edges past the accepting edge
      check(lat == TW + 1, "R9 latency", lat, TW + 1);
   endtask

   // pat 0: always ready, 1: every other cycle, 2: one in four
   task automatic collect(input bit up, input int v, input int pat, input string req);
      logic [7:0] e [8];
      logic [7:0] held;
      bit stalled;
      int k, s;
      bit r;
      expect_line(up, v, e);
      k = 0; s = 0; stalled = 0; held = 8'h00;
      while (k < 8 && s < 300) begin
         r = (pat == 0) ? 1'b1 : (pat == 1) ? s[0] : ((s % 4) == 3);
         byte_ready = r;
         if (!byte_valid) begin
            check(1'b0, "R5 valid dropped inside record", k, 8);
         end else begin
            if (stalled)
               check(byte_data == held, "R7 data held under stall", int'(byte_data), int'(held));
            if (r) begin
               check(byte_data == e[k],
                     (k == 0) ? "R2 sign" : (k < 6) ? req : "R4 line end",
                     int'(byte_data), int'(e[k]));
               k++;
               stalled = 0;
            end else begin
               stalled = 1;
               held = byte_data;
            end
         end
         s++;
         if (k < 8) @(negedge clk);
      end
      @(negedge clk);
      byte_ready = 1'b0;
      check(byte_valid == 1'b0, "R5 record length", int'(byte_valid), 0);
      check(smp_ready == 1'b1, "R6 ready after line feed", int'(smp_ready), 1);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(smp_ready == 1'b1, "R1 ready after reset", int'(smp_ready), 1);
      check(byte_valid == 1'b0, "R1 no output after reset", int'(byte_valid), 0);
   endtask

   task automatic t_values();
      send(1'b1, 12345, 1'b0); collect(1'b1, 12345, 0, "R3 digits 12345");
      send(1'b0, 4096, 1'b0);  collect(1'b0, 4096, 0, "R3 digits 4096");
      send(1'b1, 59999, 1'b0); collect(1'b1, 59999, 0, "R3 digits 59999");
      send(1'b0, 7, 1'b0);     collect(1'b0, 7, 0, "R3 digits 7");
   endtask

   task automatic t_bounds();
      send(1'b1, 0, 1'b0);     collect(1'b1, 0, 0, "R8 zero plus");
      send(1'b0, 0, 1'b0);     collect(1'b0, 0, 0, "R8 zero minus");
      send(1'b0, 65535, 1'b0); collect(1'b0, 65535, 0, "R8 max minus");
      send(1'b1, 65535, 1'b0); collect(1'b1, 65535, 0, "R8 max plus");
   endtask

   task automatic t_stall();
      send(1'b1, 31415, 1'b0); collect(1'b1, 31415, 1, "R7 digits alt ready");
      send(1'b0, 50505, 1'b0); collect(1'b0, 50505, 2, "R7 digits slow ready");
   endtask

   task automatic t_busy_ignore();
      send(1'b1, 24680, 1'b1); collect(1'b1, 24680, 1, "R6 digits held event");
      for (int i = 0; i < 20; i++) begin
         @(negedge clk);
         check(byte_valid == 1'b0, "R6 offered event ignored", int'(byte_valid), 0);
      end
   endtask

   initial begin
      while (cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      t_reset();
      t_values();
      t_bounds();
      t_stall();
      t_busy_ignore();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule